// File: doc/BRIEF.md
# Line-Interface Chip-Select Sequencer

This block sequences four active-low select strobes toward external line-interface circuits. It also carries a shared 12-bit parallel data word to and from those circuits in step with the strobes. Each of the four pins has a mode bit. In strobe mode the block drives the pin as a timed select. In static mode the pin just follows a level bit supplied from configuration.

A frame lasts `FRAME_CYCLES` system-clock cycles: 64 by default, which gives 31.25 µs at 2.048 MHz. The frame is cut into one equal slot per channel, in channel order. A strobe-mode channel pulls its pin low for all of its slot except the last cycle. While the pin is low, the block drives that channel's outgoing word onto the bus. When the pin rises, the block captures the incoming bus value into that channel's receive register.

Top module: `lic_select_sequencer`

## Requirements
- R1: On a clock edge with `rst_n` low, all `sel_n` bits become 1, `io_oe` becomes 0, and every receive word becomes 0.
- R2: With defaults (64-cycle frame, 16-cycle slots), position p runs 0..63 from the first edge after reset and wraps after 63. At the edge that evaluates position p, a strobe-mode channel c goes low when p/16 equals c and p%16 is not 15. Otherwise it goes high.
- R3: Among the strobe-mode pins, no more than one is low at any time.
- R4: A channel whose `cfg_auto` bit is 0 shows, on `sel_n`, the `cfg_static` bit it saw at the previous clock edge.
- R5: `io_oe` is 1 exactly when some strobe-mode pin is low. While it is 1, `io_out` carries that channel's outgoing word, taken from `tx_words` bits [c*12 +: 12].
- R6: At an edge where the `sel_n` of a strobe-mode channel goes from 0 to 1, that channel's receive word (`rx_words` bits [c*12 +: 12]) takes the value of `io_in` at that edge. At no other edge does it change.
- R7: A channel in static mode never drives the bus, and its receive word holds its value. This includes a strobe cut short by a switch to static mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_auto | input | 4 | Per-pin mode: 1 strobe, 0 static |
| cfg_static | input | 4 | Per-pin level used in static mode |
| tx_words | input | 48 | Outgoing words, channel c at [c*12 +: 12] |
| io_in | input | 12 | Incoming parallel bus |
| sel_n | output | 4 | Select pins, active low in strobe mode |
| io_out | output | 12 | Parallel bus drive value |
| io_oe | output | 1 | Parallel bus drive enable |
| rx_words | output | 48 | Captured words, channel c at [c*12 +: 12] |

## Verification
The bench follows the slot boundaries closely. Ending a strobe one cycle early or late, or letting two slots touch, shows up as a `sel_n` or `io_oe` mismatch at the exact cycle. Mode switches in the middle of a strobe are aimed at the capture logic. A design that captured on any rising pin, or that lost the strobe state across a switch, would corrupt a receive word that should have held. Static bits are toggled every cycle to expose an added or missing pipeline stage. Reset is applied in the middle of a frame to confirm that the frame restarts at channel 0 with the bus released.

// File: rtl/lic_sel_pkg.sv
// Shared types for the line-interface select sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package lic_sel_pkg;
    // Per-pin operating mode, encoded as the cfg_auto bit.
    typedef enum logic {
        PIN_STATIC = 1'b0,
        PIN_STROBE = 1'b1
    } pin_mode_e;
endpackage

// File: rtl/lic_frame_timer.sv
// Frame timer: counts cycles inside a slot and slots inside a frame.
// Assumes: FRAME_CYCLES is NUM_CH times a slot length of at least 2,
// and NUM_CH and the slot length are powers of two.
module lic_frame_timer #(
    parameter int NUM_CH       = 4,
    parameter int FRAME_CYCLES = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    output logic [$clog2(NUM_CH)-1:0]   slot_idx,
    output logic                        slot_last
);
    localparam int SLOT_CYC = FRAME_CYCLES / NUM_CH;
    localparam int SLOT_W   = $clog2(NUM_CH);
    localparam int OFF_W    = $clog2(SLOT_CYC);

    logic [OFF_W-1:0]  off_q;
    logic [SLOT_W-1:0] slot_q;

    assign slot_last = (off_q == OFF_W'(SLOT_CYC - 1));
    assign slot_idx  = slot_q;

    // Advance the offset; roll into the next slot and wrap the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q  <= '0;
            slot_q <= '0;
        end else if (slot_last) begin
            off_q  <= '0;
            slot_q <= (slot_q == SLOT_W'(NUM_CH - 1)) ? '0 : slot_q + 1'b1;
        end else begin
            off_q  <= off_q + 1'b1;
        end
    end
endmodule

// File: rtl/lic_pin_driver.sv
// One select pin: a timed strobe in its own slot, or a static level.
// Also flags the edge at which a strobe ends so the bus port can capture.
// Assumes: slot_idx/slot_last come from the shared frame timer.
module lic_pin_driver
    import lic_sel_pkg::*;
#(
    parameter int SLOT_W = 2,
    parameter int CH_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_bit,
    input  logic              static_lvl,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic              slot_last,
    output logic              sel_n,
    output logic              strobe_next,
    output logic              capture_en
);
    pin_mode_e mode;
    logic      sel_d;
    logic      sel_q;

    assign mode = pin_mode_e'(mode_bit);

    // Next pin level: active-low inside own slot except its last cycle.
    always_comb begin
        strobe_next = (mode == PIN_STROBE) && (slot_idx == SLOT_W'(CH_IDX)) && !slot_last;
        sel_d       = (mode == PIN_STROBE) ? !strobe_next : static_lvl;
    end

    // A strobe-mode pin rising at this edge closes a transfer.
    assign capture_en = (mode == PIN_STROBE) && !sel_q && sel_d;

    // Register the pin; released high in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 1'b1;
        else        sel_q <= sel_d;
    end

    assign sel_n = sel_q;
endmodule

// File: rtl/lic_bus_port.sv
// Parallel bus port: drives the active channel's word and captures the
// incoming word per channel at the end of its strobe.
// Assumes: at most one strobe_next bit set per cycle.
module lic_bus_port #(
    parameter int NUM_CH = 4,
    parameter int IO_W   = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CH-1:0]           strobe_next,
    input  logic [NUM_CH-1:0]           capture_en,
    input  logic [$clog2(NUM_CH)-1:0]   slot_idx,
    input  logic [NUM_CH*IO_W-1:0]      tx_words,
    input  logic [IO_W-1:0]             io_in,
    output logic [IO_W-1:0]             io_out,
    output logic                        io_oe,
    output logic [NUM_CH*IO_W-1:0]      rx_words
);
    logic [IO_W-1:0] tx_arr [NUM_CH];
    logic [IO_W-1:0] out_q;
    logic            oe_q;

    // Unpack outgoing words for slot-indexed selection.
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) tx_arr[c] = tx_words[c*IO_W +: IO_W];
    end

    // Drive enable follows the strobes; data is the current slot's word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q  <= 1'b0;
            out_q <= '0;
        end else begin
            oe_q  <= |strobe_next;
            out_q <= tx_arr[slot_idx];
        end
    end

    assign io_oe  = oe_q;
    assign io_out = out_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_rx
        logic [IO_W-1:0] rx_q;
        // Capture the bus when this channel's strobe rises.
        always_ff @(posedge clk) begin
            if (!rst_n)             rx_q <= '0;
            else if (capture_en[c]) rx_q <= io_in;
        end
        assign rx_words[c*IO_W +: IO_W] = rx_q;
    end
endmodule

// File: rtl/lic_select_sequencer.sv
// Top: four-channel select sequencer with shared parallel data bus.
// Assumes: synchronous active-low reset; configuration inputs are
// synchronous to clk.
module lic_select_sequencer #(
    parameter int NUM_CH       = 4,
    parameter int IO_W         = 12,
    parameter int FRAME_CYCLES = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CH-1:0]      cfg_auto,
    input  logic [NUM_CH-1:0]      cfg_static,
    input  logic [NUM_CH*IO_W-1:0] tx_words,
    input  logic [IO_W-1:0]        io_in,
    output logic [NUM_CH-1:0]      sel_n,
    output logic [IO_W-1:0]        io_out,
    output logic                   io_oe,
    output logic [NUM_CH*IO_W-1:0] rx_words
);
    localparam int SLOT_W = $clog2(NUM_CH);

    logic [SLOT_W-1:0] slot_idx;
    logic              slot_last;
    logic [NUM_CH-1:0] strobe_next;
    logic [NUM_CH-1:0] capture_en;

    lic_frame_timer #(.NUM_CH(NUM_CH), .FRAME_CYCLES(FRAME_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_idx  (slot_idx),
        .slot_last (slot_last)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_pin
        lic_pin_driver #(.SLOT_W(SLOT_W), .CH_IDX(c)) u_pin (
            .clk         (clk),
            .rst_n       (rst_n),
            .mode_bit    (cfg_auto[c]),
            .static_lvl  (cfg_static[c]),
            .slot_idx    (slot_idx),
            .slot_last   (slot_last),
            .sel_n       (sel_n[c]),
            .strobe_next (strobe_next[c]),
            .capture_en  (capture_en[c])
        );
    end

    lic_bus_port #(.NUM_CH(NUM_CH), .IO_W(IO_W)) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_next (strobe_next),
        .capture_en  (capture_en),
        .slot_idx    (slot_idx),
        .tx_words    (tx_words),
        .io_in       (io_in),
        .io_out      (io_out),
        .io_oe       (io_oe),
        .rx_words    (rx_words)
    );
endmodule

// File: rtl/lic_select_sequencer_chk.sv
// Checker for the select sequencer; watches top-level ports only.
module lic_select_sequencer_chk #(
    parameter int NUM_CH = 4,
    parameter int IO_W   = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_CH-1:0]      cfg_auto,
    input logic [NUM_CH-1:0]      cfg_static,
    input logic [IO_W-1:0]        io_in,
    input logic [NUM_CH-1:0]      sel_n,
    input logic                   io_oe,
    input logic [NUM_CH*IO_W-1:0] rx_words
);
    logic reset_edge_q;

    // Remember whether the last edge was a reset edge.
    always_ff @(posedge clk) reset_edge_q <= !rst_n;

    // Outputs idle after a reset edge.
    always @(negedge clk) begin
        if (reset_edge_q == 1'b1) begin
            AST_RESET_IDLE: assert (sel_n == '1 && io_oe == 1'b0 && rx_words == '0); // R1
        end
    end

    AST_ONE_STROBE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(~sel_n & $past(cfg_auto)) <= 1)); // R3

    AST_OE_TRACKS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (io_oe == |(~sel_n & $past(cfg_auto)))); // R5

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        AST_STATIC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(cfg_auto[c])) |-> (sel_n[c] == $past(cfg_static[c]))); // R4

        AST_RX_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && (rx_words[c*IO_W +: IO_W] != $past(rx_words[c*IO_W +: IO_W])))
            |-> ($rose(sel_n[c]) && $past(cfg_auto[c]))); // R6

        AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $rose(sel_n[c]) && $past(cfg_auto[c]))
            |-> (rx_words[c*IO_W +: IO_W] == $past(io_in))); // R6
    end
endmodule

bind lic_select_sequencer lic_select_sequencer_chk #(.NUM_CH(NUM_CH), .IO_W(IO_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_auto   (cfg_auto),
    .cfg_static (cfg_static),
    .io_in      (io_in),
    .sel_n      (sel_n),
    .io_oe      (io_oe),
    .rx_words   (rx_words)
);

// File: tb/test_lic_select_sequencer.sv
module test_lic_select_sequencer;
    localparam int NCH   = 4;
    localparam int IOW   = 12;
    localparam int FRAME = 64;
    localparam int SLOT  = FRAME / NCH;
    localparam int NVEC  = 7;
    // Each entry: [7:4] cfg_auto, [3:0] cfg_static.
    localparam logic [7:0] VEC [NVEC] = '{8'hF0, 8'h5A, 8'hA5, 8'h0F, 8'h30, 8'h96, 8'h00};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    cfg_auto = '0;
    logic [NCH-1:0]    cfg_static = '0;
    logic [NCH*IOW-1:0] tx_words = '0;
    logic [IOW-1:0]    io_in = '0;
    logic [NCH-1:0]    sel_n;
    logic [IOW-1:0]    io_out;
    logic              io_oe;
    logic [NCH*IOW-1:0] rx_words;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Expected state computed from the requirements.
    logic [NCH-1:0] exp_sel = '1;
    logic           exp_oe  = 1'b0;
    logic [IOW-1:0] exp_out = '0;
    logic [IOW-1:0] exp_rx [NCH];
    int             pos = 0;

    always #2 clk = ~clk;

    lic_select_sequencer i_lic_select_sequencer (
        .clk(clk), .rst_n(rst_n), .cfg_auto(cfg_auto), .cfg_static(cfg_static),
        .tx_words(tx_words), .io_in(io_in), .sel_n(sel_n), .io_out(io_out),
        .io_oe(io_oe), .rx_words(rx_words)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Update the expected outputs for one clock edge.
    task automatic model_edge();
        logic [NCH-1:0] nsel;
        int slot, off;
        if (!rst_n) begin
            exp_sel = '1; exp_oe = 1'b0; pos = 0;
            for (int c = 0; c < NCH; c++) exp_rx[c] = '0;
        end else begin
            slot = pos / SLOT; off = pos % SLOT;
            exp_oe = 1'b0;
            for (int c = 0; c < NCH; c++) begin
                bit act;
                act = cfg_auto[c] && (slot == c) && (off != SLOT - 1);
                nsel[c] = cfg_auto[c] ? !act : cfg_static[c];
                if (act) exp_oe = 1'b1;
                if (cfg_auto[c] && !exp_sel[c] && nsel[c]) exp_rx[c] = io_in;
            end
            exp_out = tx_words[slot*IOW +: IOW];
            exp_sel = nsel;
            pos = (pos + 1) % FRAME;
        end
    endtask

    // One clock: model at the edge, compare at the following falling edge.
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            string t;
            t = !rst_n ? "R1 sel" : (cfg_auto[c] ? "R2 sel" : "R4 sel");
            chk(sel_n[c] == exp_sel[c], $sformatf("%s ch%0d", t, c), 32'(sel_n[c]), 32'(exp_sel[c]));
            t = !rst_n ? "R1 rx" : (cfg_auto[c] ? "R6 rx" : "R7 rx");
            chk(rx_words[c*IOW +: IOW] == exp_rx[c], $sformatf("%s ch%0d", t, c),
                32'(rx_words[c*IOW +: IOW]), 32'(exp_rx[c]));
        end
        chk($countones(~sel_n & cfg_auto) <= 1, "R3 overlap", 32'(sel_n), 32'(cfg_auto));
        chk(io_oe == exp_oe, !rst_n ? "R1 oe" : "R5 oe", 32'(io_oe), 32'(exp_oe));
        if (exp_oe) chk(io_out == exp_out, "R5 out", 32'(io_out), 32'(exp_out));
    endtask

    task automatic set_tx(input int seed);
        for (int c = 0; c < NCH; c++) tx_words[c*IOW +: IOW] = IOW'(seed * 311 + c * 1187 + 3);
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) exp_rx[c] = '0;
        @(negedge clk);
        cfg_auto = 4'hF;
        repeat (3) tick();                       // R1 reset state
        rst_n = 1'b1;
        // Table walk: each configuration runs a little over two frames.
        for (int v = 0; v < NVEC; v++) begin
            cfg_auto   = VEC[v][7:4];
            cfg_static = VEC[v][3:0];
            set_tx(v + 1);
            for (int k = 0; k < 2 * FRAME + 7; k++) begin
                io_in = IOW'(pos * 97 + v * 13 + 5);
                tick();
            end
        end
        // R7: strobe on ch0 cut short by a switch to static mode.
        cfg_auto = 4'h1; cfg_static = 4'hF;
        while (pos != 5) begin io_in = IOW'(pos * 7 + 1); tick(); end
        cfg_auto = 4'h0;
        repeat (30) begin io_in = IOW'(pos * 5 + 9); tick(); end
        // Static low to strobe mode with no slot active: pin rises, captures (R6).
        cfg_auto = 4'h0; cfg_static = 4'h0;
        while (pos != 20) tick();
        cfg_auto = 4'h1; io_in = 12'hABC;
        tick();
        chk(rx_words[IOW-1:0] == 12'hABC, "R6 rise from static", 32'(rx_words[IOW-1:0]), 32'hABC);
        // R4: static bits changing every cycle.
        cfg_auto = 4'h0;
        for (int k = 0; k < 24; k++) begin cfg_static = 4'(k * 5 + 3); tick(); end
        // R1: reset in mid-frame, then frame restarts at channel 0.
        cfg_auto = 4'hF; set_tx(42);
        while (pos != 37) tick();
        rst_n = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
        for (int k = 0; k < FRAME + 3; k++) begin io_in = IOW'(pos * 31 + 2); tick(); end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule